// File: doc/BRIEF.md
# Buffered 16-bit Timer Register Interface

This block is a 16-bit up-counting timer that sits behind an 8-bit register port. Software reaches the count through two byte addresses, one for the low byte and one for the high byte, plus one control byte. A prescaler divides an incoming count-tick strobe by 1, 2, 4 or 8 before each increment. When the count wraps past its top value, a sticky overflow flag is raised. The flag stays set until software clears it.

The control byte selects between two ways of reaching the high byte. In direct access the high-byte address is the live high byte of the counter. In buffered access, all high-byte traffic goes through a shadow register. A low-byte read captures the live high byte into the shadow, and a low-byte write moves the shadow into the counter. Both bytes are therefore read or loaded as one atomic 16-bit value, even while the counter is running. The control byte also holds an oscillator-enable bit that is driven out of the block, and a read-only status bit that reflects an external clock-select input.

The read data is combinational on the address. The read strobe only matters for the low-byte capture it triggers in buffered mode.

Top module: `buf_timer16`

## Requirements
- R1: After reset the counter, the shadow register, the prescaler, the overflow flag and every control bit are zero. Address 0 (low byte), address 1 (high byte) and address 3 all read 0. Address 2 (control) reads 0 when the clock-select input is low.
- R2: Control bit 0 is the run enable. Control bits 5:4 hold a select s, and while run is 1 the counter advances by one on every 2^s-th count tick. While run is 0 the counter and the prescaler hold.
- R3: An increment at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag (control bit 2, also on the overflow output). The flag stays set until a control write with bit 2 at 0. A control write with bit 2 at 1 leaves the flag unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R4: With control bit 7 at 0 (direct access), address 1 reads and writes the live high byte. The shadow register is neither loaded nor read.
- R5: With control bit 7 at 1 (buffered access), a read of address 0 returns the live low byte and copies the live high byte into the shadow in the same cycle. Address 1 then reads the shadow, not the live high byte.
- R6: In buffered access, a write to address 1 loads only the shadow. A write to address 0 loads the low byte and copies the shadow into the counter's high byte in the same cycle.
- R7: Every write to address 0 clears the prescaler. A write to address 1 leaves the prescaler unchanged.
- R8: A write that changes a counter byte (an address-0 write, or a direct-access address-1 write) takes priority over an increment in the same cycle. That increment is dropped.
- R9: Control bit 6 reads the clock-select input, and writes to it are ignored. Control bit 3 drives the oscillator-enable output. Control bit 1 reads 0. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers the buffered-mode capture) |
| bus_wdata | input | BW (8) | Write data |
| bus_rdata | output | BW (8) | Read data for the selected address |
| cnt_tick | input | 1 | Count-tick strobe fed to the prescaler |
| clk_sel_tmr | input | 1 | High while the timer's own oscillator is the active system clock |
| osc_en_o | output | 1 | Oscillator enable, copy of control bit 3 |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The counter is run under each prescale select with continuous ticks and with run disabled. This separates the division ratio from the enable. Byte accesses are tried in both access modes around a low-to-high carry: reading low then high across a carry shows whether the capture happens on the low read, and a direct-mode read afterwards shows that the live byte moved on. Writes placed on the same cycle as a prescaled increment, and high-byte writes placed in the middle of a prescale period, distinguish write priority from prescaler clearing. A wrap next to flag-clearing writes shows that the flag is sticky and how set and clear are ordered.

// File: rtl/buf_tmr_pkg.sv
package buf_tmr_pkg;
  typedef enum logic [1:0] {
    A_LO   = 2'd0,
    A_HI   = 2'd1,
    A_CTRL = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // control byte bit positions
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_OVF  = 2;
  localparam int unsigned C_OSC  = 3;
  localparam int unsigned C_PS   = 4;
  localparam int unsigned C_STAT = 6;
  localparam int unsigned C_MODE = 7;

  // last prescaler state before an increment fires: 2^sel - 1
  function automatic int unsigned presc_last(input int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction
endpackage

// File: rtl/buf_tmr_presc.sv
module buf_tmr_presc
  import buf_tmr_pkg::*;
#(
  parameter int unsigned PSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           tick_i,
  input  logic           clr_i,
  input  logic [PSW-1:0] sel_i,
  output logic           fire_o
);
  localparam int unsigned PCW = (1 << PSW) - 1;

  logic [PCW-1:0] pcnt_q;
  logic           at_last;

  assign at_last = (pcnt_q >= PCW'(presc_last(32'(sel_i))));
  assign fire_o  = en_i & tick_i & at_last & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt_q <= '0;
    else if (clr_i)          pcnt_q <= '0;
    else if (en_i && tick_i) pcnt_q <= at_last ? '0 : pcnt_q + 1'b1;
  end

  assert_presc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pcnt_q == '0));
  assert_presc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/buf_tmr_count.sv
module buf_tmr_count #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_mode_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          rd_lo_i,
  input  logic          inc_i,
  input  logic [BW-1:0] wd_i,
  output logic [2*BW-1:0] cnt_o,
  output logic [BW-1:0] shadow_o,
  output logic          wrap_o
);
  localparam int unsigned CW = 2 * BW;

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] shadow_q;
  logic          wr_hi_direct, wr_hi_buf, snap_evt, inc_take;

  assign wr_hi_direct = wr_hi_i & ~buf_mode_i;
  assign wr_hi_buf    = wr_hi_i &  buf_mode_i;
  assign snap_evt     = rd_lo_i &  buf_mode_i;
  assign inc_take     = inc_i & ~wr_lo_i & ~wr_hi_direct;
  assign wrap_o       = inc_take & (cnt_q == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q <= {(buf_mode_i ? shadow_q : cnt_q[CW-1:BW]), wd_i};
    end else if (wr_hi_direct) begin
      cnt_q <= {wd_i, cnt_q[BW-1:0]};
    end else if (inc_take) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (wr_hi_buf) shadow_q <= wd_i;
    else if (snap_evt)  shadow_q <= cnt_q[CW-1:BW];
  end

  assign cnt_o    = cnt_q;
  assign shadow_o = shadow_q;

  assert_lo_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> (cnt_q[BW-1:0] == $past(wd_i)));
  assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && buf_mode_i) |=> (cnt_q[CW-1:BW] == $past(shadow_q)));
  assert_shadow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_buf |=> (shadow_q == $past(wd_i)));
  assert_snap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_evt && !wr_hi_i) |=> (shadow_q == $past(cnt_q[CW-1:BW])));
  assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_direct |=> ((cnt_q[CW-1:BW] == $past(wd_i)) && $stable(shadow_q)));
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/buf_tmr_ctrl.sv
module buf_tmr_ctrl #(
  parameter int unsigned PSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic           mode_d,
  input  logic [PSW-1:0] ps_d,
  input  logic           osc_d,
  input  logic           ovf_d,
  input  logic           run_d,
  input  logic           wrap_i,
  output logic           mode_o,
  output logic [PSW-1:0] ps_o,
  output logic           osc_o,
  output logic           ovf_o,
  output logic           run_o
);
  logic ovf_clr;
  assign ovf_clr = wr_i & ~ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= 1'b0;
      ps_o   <= '0;
      osc_o  <= 1'b0;
      run_o  <= 1'b0;
    end else if (wr_i) begin
      mode_o <= mode_d;
      ps_o   <= ps_d;
      osc_o  <= osc_d;
      run_o  <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_o <= 1'b0;
    else if (wrap_i)  ovf_o <= 1'b1;
    else if (ovf_clr) ovf_o <= 1'b0;
  end

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> ovf_o);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr) |=> ovf_o);
  assert_ovf_noset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_o && !wrap_i) |=> !ovf_o);
endmodule

// File: rtl/buf_timer16.sv
module buf_timer16
  import buf_tmr_pkg::*;
#(
  parameter int unsigned BW  = 8,
  parameter int unsigned PSW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          cnt_tick,
  input  logic          clk_sel_tmr,
  output logic          osc_en_o,
  output logic          ovf_o
);
  localparam int unsigned CW = 2 * BW;

  logic          wr_lo, wr_hi, wr_ctrl, rd_lo;
  logic          mode_q, osc_q, ovf_q, run_q;
  logic [PSW-1:0] ps_q;
  logic          inc_evt, wrap_evt;
  logic [CW-1:0] cnt;
  logic [BW-1:0] shadow, ctrl_rd;

  assign wr_lo   = bus_wr & (bus_addr == A_LO);
  assign wr_hi   = bus_wr & (bus_addr == A_HI);
  assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
  assign rd_lo   = bus_rd & (bus_addr == A_LO);

  buf_tmr_presc #(.PSW(PSW)) u_presc (
    .clk(clk), .rst_n(rst_n), .en_i(run_q), .tick_i(cnt_tick),
    .clr_i(wr_lo), .sel_i(ps_q), .fire_o(inc_evt)
  );

  buf_tmr_count #(.BW(BW)) u_count (
    .clk(clk), .rst_n(rst_n), .buf_mode_i(mode_q), .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi), .rd_lo_i(rd_lo), .inc_i(inc_evt), .wd_i(bus_wdata),
    .cnt_o(cnt), .shadow_o(shadow), .wrap_o(wrap_evt)
  );

  buf_tmr_ctrl #(.PSW(PSW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl),
    .mode_d(bus_wdata[C_MODE]), .ps_d(bus_wdata[C_PS +: PSW]),
    .osc_d(bus_wdata[C_OSC]), .ovf_d(bus_wdata[C_OVF]), .run_d(bus_wdata[C_RUN]),
    .wrap_i(wrap_evt),
    .mode_o(mode_q), .ps_o(ps_q), .osc_o(osc_q), .ovf_o(ovf_q), .run_o(run_q)
  );

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[C_MODE]      = mode_q;
    ctrl_rd[C_STAT]      = clk_sel_tmr;
    ctrl_rd[C_PS +: PSW] = ps_q;
    ctrl_rd[C_OSC]       = osc_q;
    ctrl_rd[C_OVF]       = ovf_q;
    ctrl_rd[C_RUN]       = run_q;
  end

  always_comb begin
    unique case (bus_addr)
      A_LO:    bus_rdata = cnt[BW-1:0];
      A_HI:    bus_rdata = mode_q ? shadow : cnt[CW-1:BW];
      A_CTRL:  bus_rdata = ctrl_rd;
      default: bus_rdata = '0;
    endcase
  end

  assign osc_en_o = osc_q;
  assign ovf_o    = ovf_q;

  assert_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[C_STAT] == clk_sel_tmr));
  assert_hi_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && bus_addr == A_HI) |-> (bus_rdata == shadow));
endmodule

// File: tb/buf_timer16_bench.sv
module buf_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, cnt_tick = 1'b0, clk_sel_tmr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       osc_en_o, ovf_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_sh, m_pc, m_ps;
  bit m_ovf, m_mode, m_osc, m_run;

  always #4 clk = ~clk;   // 125 MHz

  buf_timer16 u_buf_timer16 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .clk_sel_tmr(clk_sel_tmr),
    .osc_en_o(osc_en_o), .ovf_o(ovf_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sh = 0; m_pc = 0; m_ps = 0;
      m_ovf = 0; m_mode = 0; m_osc = 0; m_run = 0;
    end else begin
      int  old_cnt, div;
      bit  fire, wlo, whd, wrapped;
      old_cnt = m_cnt;
      div     = 1 << m_ps;
      wlo     = bus_wr && bus_addr == 2'd0;
      whd     = bus_wr && bus_addr == 2'd1 && !m_mode;
      fire    = m_run && cnt_tick && (m_pc >= div - 1) && !wlo;
      wrapped = 0;
      if (wlo) m_pc = 0;
      else if (m_run && cnt_tick) m_pc = (m_pc >= div - 1) ? 0 : m_pc + 1;
      if (wlo)      m_cnt = ((m_mode ? m_sh : (old_cnt >> 8)) << 8) | bus_wdata;
      else if (whd) m_cnt = (bus_wdata << 8) | (old_cnt & 255);
      else if (fire) begin
        if (old_cnt == 65535) begin m_cnt = 0; wrapped = 1; end
        else m_cnt = old_cnt + 1;
      end
      if (m_mode && bus_wr && bus_addr == 2'd1) m_sh = bus_wdata;
      else if (m_mode && bus_rd && bus_addr == 2'd0) m_sh = (old_cnt >> 8) & 255;
      if (wrapped) m_ovf = 1;
      else if (bus_wr && bus_addr == 2'd2 && !bus_wdata[2]) m_ovf = 0;
      if (bus_wr && bus_addr == 2'd2) begin
        m_mode = bus_wdata[7]; m_ps = int'(bus_wdata[5:4]);
        m_osc = bus_wdata[3]; m_run = bus_wdata[0];
      end
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return m_cnt & 255;
      1: return m_mode ? m_sh : (m_cnt >> 8) & 255;
      2: return (int'(m_mode) << 7) | (int'(clk_sel_tmr) << 6) | (m_ps << 4) |
                (int'(m_osc) << 3) | (int'(m_ovf) << 2) | int'(m_run);
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: flags compared, inputs applied, read checked, then edge
  task automatic cyc(input bit wr, input bit rd, input int a, input int d,
                     input bit t, input string tag);
    check(ovf_o == m_ovf, "R3 overflow output", ovf_o, m_ovf);
    check(osc_en_o == m_osc, "R9 oscillator enable", osc_en_o, m_osc);
    bus_wr = wr; bus_rd = rd; bus_addr = 2'(a); bus_wdata = 8'(d); cnt_tick = t;
    #1;
    if (rd) check(int'(bus_rdata) == model_rd(a), tag, bus_rdata, model_rd(a));
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; cnt_tick = 0;
  endtask

  task automatic rd(input int a, input string tag);
    cyc(0, 1, a, 0, 0, tag);
  endtask

  task automatic wr(input int a, input int d);
    cyc(1, 0, a, d, 0, "write");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, "tick");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, "R1 low after reset"); rd(1, "R1 high after reset");
    rd(2, "R1 ctrl after reset"); rd(3, "R1 unused address");
    // R2 run disabled: ticks do nothing
    ticks(5); rd(0, "R2 stopped counter");
    // R2 prescale 1 and 4
    wr(2, 8'h01); ticks(5); rd(0, "R2 prescale 1");
    wr(2, 8'h21); ticks(9); rd(0, "R2 prescale 4");
    wr(2, 8'h31); ticks(17); rd(0, "R2 prescale 8");
    // R4 direct high access, shadow untouched
    wr(2, 8'h00); wr(1, 8'h12); rd(1, "R4 direct high write");
    rd(0, "R4 low unchanged");
    wr(2, 8'h80); rd(1, "R4 shadow untouched by direct traffic");
    // R6 buffered high write only loads shadow
    wr(1, 8'h34); wr(2, 8'h00); rd(1, "R6 live high unchanged by buffered write");
    wr(2, 8'h80); wr(0, 8'hFF); rd(0, "R6 low loaded"); wr(2, 8'h00);
    rd(1, "R6 shadow committed on low write");
    // R5 atomic read across carry
    wr(2, 8'h81); cyc(0, 1, 0, 0, 1, "R5 low read at carry");
    rd(1, "R5 high read returns captured byte");
    wr(2, 8'h00); rd(1, "R5 live high moved on"); rd(0, "R5 live low");
    // R7 high write keeps prescaler, low write clears it
    wr(2, 8'hB0); wr(1, 8'h00); wr(0, 8'h00); wr(2, 8'hB1);
    ticks(4); wr(1, 8'h77); ticks(4); rd(0, "R7 high write keeps prescaler");
    ticks(4); wr(0, 8'h20); ticks(4); rd(0, "R7 low write clears prescaler");
    ticks(4); rd(0, "R7 increment after full period");
    // R8 write beats increment
    wr(2, 8'h01); ticks(2);
    cyc(1, 0, 0, 8'h50, 1, "R8 low write with increment"); rd(0, "R8 low write wins");
    cyc(1, 0, 1, 8'h66, 1, "R8 high write with increment");
    rd(1, "R8 direct high wins"); rd(0, "R8 low not incremented");
    // R3 wrap, sticky, clear rules
    wr(2, 8'h00); wr(1, 8'hFF); wr(0, 8'hFE); wr(2, 8'h01);
    ticks(2); rd(0, "R3 wrapped low"); rd(1, "R3 wrapped high"); rd(2, "R3 flag set");
    ticks(3); wr(2, 8'h05); rd(2, "R3 write one keeps flag");
    wr(2, 8'h00); rd(2, "R3 write zero clears flag");
    wr(1, 8'hFF); wr(0, 8'hFF); wr(2, 8'h05); rd(2, "R3 setup before coincident clear");
    cyc(1, 0, 2, 8'h01, 1, "R3 wrap with clearing write"); rd(2, "R3 set wins over clear");
    // R9 status bit, osc enable, unused address
    clk_sel_tmr = 1; wr(2, 8'h08); rd(2, "R9 status follows input, bit6 write ignored");
    wr(2, 8'h40); rd(2, "R9 status write ignored, osc cleared");
    clk_sel_tmr = 0; wr(2, 8'h0A); rd(2, "R9 bit1 reads zero");
    wr(3, 8'hFF); rd(0, "R9 unused write no effect on low"); rd(1, "R9 unused write high");
    rd(2, "R9 unused write ctrl"); rd(3, "R9 unused reads zero");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule